// File: doc/BRIEF.md
# Serial Transceiver with Line Break Control

A register-controlled serial transceiver that runs either as an asynchronous line (start bit, eight data bits least significant first, optional parity, one stop bit) or as a clocked synchronous link that drives its own serial clock. Software reaches it through a four-word register bus: a control word, a status word, a transmit data word and a receive data word. A baud tick input sets the timing. One bit lasts `OVS` ticks in both modes, and the asynchronous receiver samples each bit in its middle.

While the transmitter is disabled, the transmit pin is handed to a port override made of a direction bit and a data bit. Software uses it to park the line at mark level, to send a break, or to release the pin. Clearing the transmit enable in the middle of a frame aborts the frame at once. A break on the receive line shows up as a framing error. The synchronised level of the receive pin can be read from status, so software can confirm that the line is still low.

In synchronous mode, a pending receive error stops new transfers from starting. Error flags use a read-then-write-zero clear, and disabling the receiver leaves them untouched.

Top module: `serial_xcvr`

## Requirements
- R1: After reset the status word (address 1) reads 0x21: tx_empty (bit 0) = 1, rx_full (bit 1) = 0, overrun (bit 2), parity error (bit 3) and framing error (bit 4) all 0, and bit 5 shows the idle-high receive line. `txd_oe` is 0 and `sclk` is 1.
- R2: While tx_en (control bit 0) is 0, port_dir (control bit 5) = 1 drives `txd` with port_dat (control bit 6) and asserts `txd_oe`, giving mark for 1 and break for 0. port_dir = 0 deasserts `txd_oe`.
- R3: In asynchronous mode the transmitter sends 0, eight data bits LSB first, then parity if par_en (control bit 3) is set (even, or odd when control bit 4 is set), then 1. Each bit lasts OVS ticks and `txd` idles at 1 between frames.
- R4: Clearing tx_en aborts any frame in the next cycle and sets tx_empty. The pin follows the port override from the write onward. Data written to address 2 while tx_en is 0 is dropped.
- R5: A write to address 2 clears tx_empty. tx_empty returns to 1 in the cycle the frame starts.
- R6: With rx_en (control bit 1) set in asynchronous mode, a received frame places its byte at address 3 and sets rx_full. Writing 0 to status bit 1 clears rx_full. Reading address 3 does not clear it.
- R7: A received parity bit that does not match the selected parity sets the parity error flag. The byte is still stored.
- R8: A stop bit sampled as 0 sets the framing error flag. A line held low sets it, and if software clears it while the line stays low, the next frame sets it again.
- R9: A frame that completes while rx_full is 1 sets the overrun flag and is discarded, so address 3 keeps the older byte.
- R10: An error flag clears only when a status write carries 0 in its bit and a status read returned that bit as 1 earlier. A zero write without the read, or a write of 1, leaves it set.
- R11: Clearing rx_en does not clear any error flag.
- R12: Status bit 5 returns the synchronised level of `rxd`.
- R13: In synchronous mode (control bit 2) a transfer is eight bits LSB first with no framing bits. `sclk` is low for the first half of each bit and high for the second. `txd` changes as `sclk` falls, and `rxd` is sampled as it rises.
- R14: In synchronous mode no transfer starts while any error flag is 1, even when tx_empty is 0. The transfer starts once the flags are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Baud tick, OVS per bit |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 transmit data, 3 receive data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (arms error flags for clearing) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| txd_oe | output | 1 | Output enable for txd |
| sclk | output | 1 | Serial clock in synchronous mode, high otherwise |

## Verification
A behavioural pin model predicts `txd`, `txd_oe` and `sclk` on every clock. It is exercised with asynchronous frames without parity, with even parity and with odd parity, with a tick that is present only every other cycle, with a frame aborted mid-way, and with port override patterns for mark, break and release. Together these separate bit order, bit length and parity polarity from abort timing. Receive patterns include a clean frame, right and wrong parity, back-to-back frames with no read, and a held-low line. These tell overrun apart from framing error and confirm that the framing error is set again after a clear. A synchronous loopback transfer checks the edge relation, and a synchronous write made while an error flag is pending shows that the start is held back until the flags are cleared.

// File: rtl/serial_xcvr.sv
module serial_xcvr #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       rxd,
  output logic       txd,
  output logic       txd_oe,
  output logic       sclk
);
  localparam int CW = $clog2(OVS);
  localparam int HALF = OVS / 2;
  localparam logic [CW-1:0] CNT_END = CW'(OVS - 1);
  localparam logic [CW-1:0] CNT_MID = CW'(HALF - 1);

  logic tx_en, rx_en, sync_md, par_en, par_odd, port_dir, port_dat;
  logic ctl_wr, st_wr, st_rd, td_wr;
  assign ctl_wr = bus_wr && bus_addr == 2'd0;
  assign st_wr  = bus_wr && bus_addr == 2'd1;
  assign st_rd  = bus_rd && bus_addr == 2'd1;
  assign td_wr  = bus_wr && bus_addr == 2'd2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {port_dat, port_dir, par_odd, par_en, sync_md, rx_en, tx_en} <= '0;
    else if (ctl_wr) {port_dat, port_dir, par_odd, par_en, sync_md, rx_en, tx_en} <= bus_wdata[6:0];

  logic [2:0] err, arm, err_set;
  logic [7:0] tx_buf;
  logic tx_empty, tx_busy, tx_go;
  logic [10:0] tx_sh;
  logic [CW-1:0] tx_cnt;
  logic [3:0] tx_bit, tx_last;

  assign tx_go = tx_en && !tx_busy && !tx_empty && !(sync_md && |err);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_busy <= 1'b0; tx_empty <= 1'b1; tx_cnt <= '0; tx_bit <= '0;
      tx_last <= '0; tx_sh <= '1; tx_buf <= '0;
    end else if (!tx_en) begin
      tx_busy <= 1'b0; tx_empty <= 1'b1; tx_cnt <= '0; tx_bit <= '0;
    end else begin
      if (tx_go) begin
        tx_busy <= 1'b1; tx_empty <= 1'b1; tx_cnt <= '0; tx_bit <= '0;
        if (sync_md) begin
          tx_sh <= {3'b111, tx_buf}; tx_last <= 4'd7;
        end else if (par_en) begin
          tx_sh <= {1'b1, ^tx_buf ^ par_odd, tx_buf, 1'b0}; tx_last <= 4'd10;
        end else begin
          tx_sh <= {2'b11, tx_buf, 1'b0}; tx_last <= 4'd9;
        end
      end else if (tx_busy && tick) begin
        if (tx_cnt == CNT_END) begin
          tx_cnt <= '0;
          if (tx_bit == tx_last) tx_busy <= 1'b0;
          else begin
            tx_bit <= tx_bit + 4'd1;
            tx_sh  <= {1'b1, tx_sh[10:1]};
          end
        end else tx_cnt <= tx_cnt + 1'b1;
      end
      if (td_wr) begin
        tx_buf <= bus_wdata; tx_empty <= 1'b0;
      end
    end

  assign txd    = tx_en ? (tx_busy ? tx_sh[0] : 1'b1) : port_dat;
  assign txd_oe = tx_en | port_dir;
  assign sclk   = !(sync_md && tx_busy && tx_cnt < CW'(HALF));

  logic rxd_m, rxd_s;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {rxd_s, rxd_m} <= 2'b11;
    else {rxd_s, rxd_m} <= {rxd_m, rxd};

  logic rx_act, rx_par, rx_full;
  logic [CW-1:0] rx_cnt;
  logic [3:0] rx_bit, stop_idx;
  logic [7:0] rx_sh, rx_buf, rx_data;
  logic async_on, a_done, s_smp, s_done, rx_done;

  assign stop_idx = par_en ? 4'd10 : 4'd9;
  assign async_on = rx_en && !sync_md;
  assign a_done   = async_on && rx_act && tick && rx_bit == stop_idx && rx_cnt == CNT_END;
  assign s_smp    = rx_en && sync_md && tx_busy && tick && tx_cnt == CNT_MID;
  assign s_done   = s_smp && rx_bit == 4'd7;
  assign rx_done  = a_done || s_done;
  assign rx_data  = s_done ? {rxd_s, rx_sh[7:1]} : rx_sh;
  assign err_set  = {a_done && !rxd_s,
                     a_done && par_en && (rx_par != (^rx_sh ^ par_odd)),
                     rx_done && rx_full};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_act <= 1'b0; rx_cnt <= '0; rx_bit <= '0; rx_sh <= '0; rx_par <= 1'b0;
    end else if (async_on) begin
      if (!rx_act) begin
        if (!rxd_s) begin
          rx_act <= 1'b1; rx_cnt <= '0; rx_bit <= '0;
        end
      end else if (tick) begin
        if (rx_bit == 4'd0) begin
          if (rx_cnt == CNT_MID) begin
            if (rxd_s) rx_act <= 1'b0;
            else begin
              rx_cnt <= '0; rx_bit <= 4'd1;
            end
          end else rx_cnt <= rx_cnt + 1'b1;
        end else if (rx_cnt == CNT_END) begin
          rx_cnt <= '0;
          rx_bit <= rx_bit + 4'd1;
          if (rx_bit <= 4'd8) rx_sh <= {rxd_s, rx_sh[7:1]};
          if (rx_bit == 4'd9) rx_par <= rxd_s;
          if (rx_bit == stop_idx) rx_act <= 1'b0;
        end else rx_cnt <= rx_cnt + 1'b1;
      end
    end else begin
      rx_act <= 1'b0;
      if (!tx_busy) rx_bit <= '0;
      else if (s_smp) begin
        rx_bit <= rx_bit + 4'd1;
        rx_sh  <= {rxd_s, rx_sh[7:1]};
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_full <= 1'b0; rx_buf <= '0; err <= '0; arm <= '0;
    end else begin
      if (st_wr && !bus_wdata[1]) rx_full <= 1'b0;
      if (rx_done && !rx_full) begin
        rx_buf <= rx_data; rx_full <= 1'b1;
      end
      for (int i = 0; i < 3; i++) begin
        if (st_wr && !bus_wdata[i+2] && arm[i]) begin
          err[i] <= 1'b0; arm[i] <= 1'b0;
        end else if (st_rd && err[i]) arm[i] <= 1'b1;
        if (err_set[i]) err[i] <= 1'b1;
      end
    end

  always_comb
    case (bus_addr)
      2'd0: bus_rdata = {1'b0, port_dat, port_dir, par_odd, par_en, sync_md, rx_en, tx_en};
      2'd1: bus_rdata = {2'b00, rxd_s, err, rx_full, tx_empty};
      2'd2: bus_rdata = tx_buf;
      default: bus_rdata = rx_buf;
    endcase

  // R4
  tx_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !tx_busy);
  // R14
  sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_md && (|err) && !tx_busy |=> !tx_busy);
  // R9
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && rx_full |=> err[0]);
  // R10
  ferr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err[2] && !(st_wr && arm[2]) |=> err[2]);
  // R11
  rx_off_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en && err[1] && !st_wr |=> err[1]);
endmodule

// File: tb/serial_xcvr_bench.sv
`timescale 1ns/1ps
module serial_xcvr_bench;
  logic clk = 0, rst_n = 0, tick = 1, slow = 0;
  logic [1:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0, rxd_drv = 1, loop = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic rxd, txd, txd_oe, sclk;
  int total = 0, bad = 0, cyc = 0;

  assign rxd = loop ? txd : rxd_drv;
  always #4 clk = ~clk;
  always @(negedge clk) tick <= slow ? ~tick : 1'b1;

  serial_xcvr u_serial_xcvr (.clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rxd(rxd), .txd(txd), .txd_oe(txd_oe), .sclk(sclk));

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // reference pin model
  bit m_txen, m_sync, m_par, m_odd, m_dir, m_dat, m_busy, m_empty;
  bit [7:0] m_buf;
  int m_cnt, m_clr, clr_mark;
  bit err_seen;
  bit mq[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      {m_txen, m_sync, m_par, m_odd, m_dir, m_dat, m_busy} = '0;
      m_empty = 1; m_cnt = 0; m_buf = 0; m_clr = 0; mq.delete();
    end else begin
      if (!m_txen) begin
        m_busy = 0; m_empty = 1; m_cnt = 0; mq.delete();
      end else if (!m_busy) begin
        if (!m_empty && !(m_sync && err_seen && m_clr == clr_mark)) begin
          mq.delete();
          if (!m_sync) mq.push_back(1'b0);
          for (int i = 0; i < 8; i++) mq.push_back(m_buf[i]);
          if (!m_sync) begin
            if (m_par) mq.push_back(^m_buf ^ m_odd);
            mq.push_back(1'b1);
          end
          m_busy = 1; m_empty = 1; m_cnt = 0;
        end
      end else if (tick) begin
        m_cnt++;
        if (m_cnt == 16) begin
          m_cnt = 0; void'(mq.pop_front());
          if (mq.size() == 0) m_busy = 0;
        end
      end
      if (bus_wr && bus_addr == 2 && m_txen) begin m_buf = bus_wdata; m_empty = 0; end
      if (bus_wr && bus_addr == 1 && bus_wdata[4:2] == 0) m_clr++;
      if (bus_wr && bus_addr == 0)
        {m_dat, m_dir, m_odd, m_par, m_sync} = bus_wdata[6:2];
      if (bus_wr && bus_addr == 0) m_txen = bus_wdata[0];
    end
  end

  always @(negedge clk) if (rst_n) begin
    cyc++;
    // R2/R3/R13 pin comparison every cycle
    check("R2/R3/R13 txd_oe", txd_oe, m_txen | m_dir);
    check("R2/R3/R13 txd", txd, m_txen ? (m_busy ? mq[0] : 1'b1) : m_dat);
    check("R13 sclk", sclk, !(m_sync && m_busy && m_cnt < 8));
    if (cyc == 150000) begin
      bad++; total++;
      $display("FAIL watchdog got=%0d exp=done", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask
  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask
  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; #1 d = bus_rdata;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic send_rx(input logic [7:0] d, input bit use_par, input bit pv);
    bit fr[$];
    fr.push_back(1'b0);
    for (int i = 0; i < 8; i++) fr.push_back(d[i]);
    if (use_par) fr.push_back(pv);
    fr.push_back(1'b1);
    foreach (fr[i]) begin
      @(negedge clk); rxd_drv = fr[i];
      idle(15);
    end
    idle(32);
  endtask

  logic [7:0] v;
  initial begin
    idle(3); rst_n = 1; idle(2);
    peek(1, v); check("R1 status", v, 8'h21);
    check("R1 oe", txd_oe, 0); check("R1 sclk", sclk, 1);

    wr(0, 8'h60); check("R2 mark txd", txd, 1); check("R2 mark oe", txd_oe, 1);
    wr(0, 8'h20); check("R2 break txd", txd, 0); check("R2 break oe", txd_oe, 1);
    wr(0, 8'h00); check("R2 release oe", txd_oe, 0);

    wr(0, 8'h61); wr(2, 8'hA5);
    peek(1, v); check("R5 empty cleared", v[0], 0);
    idle(2); peek(1, v); check("R5 empty set at start", v[0], 1);
    idle(200);
    wr(0, 8'h69); wr(2, 8'h3C); idle(200);
    wr(0, 8'h79); slow = 1; wr(2, 8'h01); idle(400); slow = 0; idle(2);
    peek(1, v); check("R3 idle after frames", v[0], 1);

    wr(0, 8'h61); wr(2, 8'hF0); idle(40);
    wr(0, 8'h20); check("R4 abort txd", txd, 0); check("R4 abort oe", txd_oe, 1);
    idle(2); peek(1, v); check("R4 empty after abort", v[0], 1);
    wr(2, 8'h55); wr(0, 8'h61); idle(200);
    peek(1, v); check("R4 dropped write", v[0], 1);

    wr(0, 8'h62);
    send_rx(8'h5A, 0, 0);
    rd(1, v); check("R6 rx_full", v[1], 1);
    rd(3, v); check("R6 data", v, 8'h5A);
    rd(1, v); check("R6 full after data read", v[1], 1);
    wr(1, 8'hFD); peek(1, v); check("R6 full cleared", v[1], 0);

    wr(0, 8'h6A);
    send_rx(8'h07, 1, 1);
    rd(1, v); check("R7 good parity", v[3], 0); check("R6 full", v[1], 1);
    wr(1, 8'hFD);
    send_rx(8'h03, 1, 1);
    peek(1, v); check("R7 bad parity", v[3], 1);
    rd(3, v); check("R7 data kept", v, 8'h03);
    wr(1, 8'hF7); peek(1, v); check("R10 no clear without read", v[3], 1);
    wr(1, 8'hFF); peek(1, v); check("R10 write one keeps", v[3], 1);
    rd(1, v); wr(1, 8'hF5); peek(1, v);
    check("R10 cleared after read", v[3], 0); check("R6 cleared", v[1], 0);

    wr(0, 8'h62);
    rxd_drv = 0; idle(192);
    rd(1, v); check("R8 break ferr", v[4], 1); check("R12 level low", v[5], 0);
    wr(1, 8'hEF); peek(1, v); check("R8 ferr cleared", v[4], 0);
    idle(192); peek(1, v); check("R8 ferr again", v[4], 1);
    rxd_drv = 1; idle(192);
    rd(1, v); wr(1, 8'h00); peek(1, v); check("R12 level high", v, 8'h21);

    send_rx(8'h11, 0, 0); send_rx(8'h22, 0, 0);
    rd(1, v); check("R9 overrun", v[2], 1);
    rd(3, v); check("R9 old data kept", v, 8'h11);
    wr(0, 8'h60);
    rd(1, v); check("R11 flag kept", v[2], 1);
    wr(1, 8'h00); peek(1, v); check("R11 clear", v, 8'h21);

    loop = 1; wr(0, 8'h67); wr(2, 8'h96); idle(160);
    rd(1, v); check("R13 rx_full", v[1], 1);
    rd(3, v); check("R13 loopback data", v, 8'h96);
    wr(1, 8'hFD);

    loop = 0; wr(0, 8'h62);
    rxd_drv = 0; idle(192); rxd_drv = 1; idle(192);
    rd(1, v); check("R8 ferr for sync hold", v[4], 1);
    clr_mark = m_clr; err_seen = 1;
    wr(0, 8'h67); wr(2, 8'h33); idle(300);
    peek(1, v); check("R14 held", v[0], 0);
    wr(1, 8'h00); idle(3);
    peek(1, v); check("R14 started", v[0], 1);
    idle(160);
    rd(3, v); check("R13 sync rx idle line", v, 8'hFF);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule